// File: doc/BRIEF.md
# Dual-Register Reload and Capture Timer

A 16-bit down-counter paired with two 16-bit holding registers, A and B. Depending on the mode held in an 8-bit control byte, the holding registers act as alternating reload values, are unused while the counter free-runs and wraps, or latch the running count when a rising edge arrives on one of two external input pins. The control byte also carries two pending/enable pairs. It raises two interrupt requests, one per channel.

Software writes the control byte, presets the counter and loads the holding registers through plain write strobes that share one data bus. The control byte, the count and both holding registers can be read at all times on output ports. A pending flag is sticky: hardware sets it, and only a software write of 0 to that bit clears it. Control bit 4 changes meaning with the mode. In the reload and free-running modes it starts and stops the counter. In capture mode it is the underflow pending flag.

Top module: `dual_reg_timer`

## Requirements
- R1: Synchronous reset clears the control byte to 0x00 and the counter to 0, and drives both interrupt outputs low. Reset leaves the contents of holding registers A and B unchanged.
- R2: Control byte fields: [7:5] mode, [4] run/underflow-pending, [3] pending A, [2] enable A, [1] pending B, [0] enable B. The mode codes are 1 for reload, 2 for free-run and 3 for capture. Any other mode value halts the counter.
- R3: In reload mode and in free-run mode, bit 4 = 1 makes the counter decrement by one per clock and bit 4 = 0 holds it. In capture mode the counter always decrements.
- R4: In reload mode, a count of 0 reloads the counter on the next clock. The first reload after entering the mode takes register A, and later reloads alternate B, A, B. Only a reload from A sets pending A.
- R5: In free-run mode the counter wraps from 0 to 0xFFFF and sets pending A at the wrap.
- R6: In capture mode a wrap from 0 to 0xFFFF sets bit 4, which then acts as the underflow pending flag.
- R7: In capture mode, each input pin passes through a two-flop synchronizer and an edge detector. A pin that is high at clock edge k, after being low, copies into its holding register at edge k+2 the count held just before that edge, and sets pending A (pin A) or pending B (pin B). Outside capture mode, pin edges have no effect.
- R8: A pending flag clears only when software writes 0 to its bit. Writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R9: irq_a = enable A AND (pending A OR (capture mode AND bit 4)), and irq_b = enable B AND pending B. Both update on the same clock edge as the control byte.
- R10: A counter preset overrides counting in the same cycle and suppresses any underflow at that edge. A capture overrides a software load of the same holding register.
- R11: Whether a write to bit 4 sets it directly or follows the pending rule of R8 depends on the mode held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the control byte |
| cfg_wr_data | input | 8 | Control byte write data |
| ld_timer | input | 1 | Preset the counter from ld_data |
| ld_hold_a | input | 1 | Load holding register A from ld_data |
| ld_hold_b | input | 1 | Load holding register B from ld_data |
| ld_data | input | 16 | Shared load data |
| pin_a | input | 1 | Asynchronous capture input A |
| pin_b | input | 1 | Asynchronous capture input B |
| ctrl_q | output | 8 | Current control byte |
| timer_q | output | 16 | Current count |
| hold_a_q | output | 16 | Holding register A |
| hold_b_q | output | 16 | Holding register B |
| irq_a | output | 1 | Channel A interrupt request |
| irq_b | output | 1 | Channel B interrupt request |

## Verification
The hardest cases to reach are coincidences in a single cycle. These are a clearing write to the control byte that lands on the same edge as an underflow, and a software load of a holding register that lands on the same edge as a capture. The stimulus reaches them by presetting the counter to a small known value, or by raising a pin a known number of cycles ahead, so that the write strobe falls exactly on the event edge. A behavioural model tracks every register through a long random phase, which also exercises mode changes while a bit-4 pending flag is set.

// File: rtl/dt_pkg.sv
`timescale 1ns/1ps
package dt_pkg;
  localparam logic [2:0] MODE_RELOAD = 3'd1;
  localparam logic [2:0] MODE_FREE   = 3'd2;
  localparam logic [2:0] MODE_CAPT   = 3'd3;

  typedef struct packed {
    logic [2:0] mode;
    logic       run_uf;
    logic       pnd_a;
    logic       en_a;
    logic       pnd_b;
    logic       en_b;
  } ctrl_t;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/dt_pin_sync.sv
`timescale 1ns/1ps
module dt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[LAST-1:0], pin};
  end

  assign rise = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/dt_counter.sv
`timescale 1ns/1ps
module dt_counter
  import dt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   mode,
  input  logic         run_bit,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic [W-1:0] rel_a,
  input  logic [W-1:0] rel_b,
  output logic [W-1:0] cnt_q,
  output logic         uf,
  output logic         uf_rel_a
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         run;
  logic         sel_b_q;
  logic [W-1:0] cnt_d;
  logic         is_reload;

  assign is_reload = (mode == MODE_RELOAD);
  assign run = (((mode == MODE_RELOAD) || (mode == MODE_FREE)) && run_bit)
               || (mode == MODE_CAPT);
  assign uf = run && (cnt_q == '0) && !load;
  assign uf_rel_a = uf && is_reload && !sel_b_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_data;
    end else if (run) begin
      if (uf && is_reload) cnt_d = sel_b_q ? rel_b : rel_a;
      else                 cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sel_b_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (!is_reload) sel_b_q <= 1'b0;
      else if (uf)    sel_b_q <= ~sel_b_q;
    end
  end
endmodule

// File: rtl/dt_hold_reg.sv
`timescale 1ns/1ps
module dt_hold_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         cap,
  input  logic [W-1:0] cap_val,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (cap)     q <= cap_val;
    else if (wr) q <= wr_data;
  end
endmodule

// File: rtl/dt_ctrl.sv
`timescale 1ns/1ps
module dt_ctrl
  import dt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       set_a,
  input  logic       set_b,
  input  logic       set_uf,
  output ctrl_t      ctrl_q,
  output logic       irq_a,
  output logic       irq_b
);
  ctrl_t wd;
  ctrl_t ctrl_d;
  logic  capt_old;

  assign wd       = ctrl_t'(wr_data);
  assign capt_old = (ctrl_q.mode == MODE_CAPT);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.mode = wd.mode;
      ctrl_d.en_a = wd.en_a;
      ctrl_d.en_b = wd.en_b;
    end
    ctrl_d.pnd_a = set_a | (ctrl_q.pnd_a & (~wr_en | wd.pnd_a));
    ctrl_d.pnd_b = set_b | (ctrl_q.pnd_b & (~wr_en | wd.pnd_b));
    if (capt_old)
      ctrl_d.run_uf = set_uf | (ctrl_q.run_uf & (~wr_en | wd.run_uf));
    else if (wr_en)
      ctrl_d.run_uf = wd.run_uf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      irq_a  <= 1'b0;
      irq_b  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_a  <= ctrl_d.en_a &
                (ctrl_d.pnd_a | ((ctrl_d.mode == MODE_CAPT) & ctrl_d.run_uf));
      irq_b  <= ctrl_d.en_b & ctrl_d.pnd_b;
    end
  end
endmodule

// File: rtl/dual_reg_timer.sv
`timescale 1ns/1ps
module dual_reg_timer
  import dt_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_wr_en,
  input  logic [7:0]   cfg_wr_data,
  input  logic         ld_timer,
  input  logic         ld_hold_a,
  input  logic         ld_hold_b,
  input  logic [W-1:0] ld_data,
  input  logic         pin_a,
  input  logic         pin_b,
  output logic [7:0]   ctrl_q,
  output logic [W-1:0] timer_q,
  output logic [W-1:0] hold_a_q,
  output logic [W-1:0] hold_b_q,
  output logic         irq_a,
  output logic         irq_b
);
  ctrl_t ctrl;
  logic  uf, uf_rel_a;
  logic  capt;
  logic  set_a, set_b, set_uf;

  logic [NUM_CH-1:0]        pins, rises, caps, lds;
  logic [NUM_CH-1:0][W-1:0] holds;

  assign pins = {pin_b, pin_a};
  assign lds  = {ld_hold_b, ld_hold_a};
  assign capt = (ctrl.mode == MODE_CAPT);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (pins[i]),
      .rise(rises[i])
    );
    assign caps[i] = capt & rises[i];
    dt_hold_reg #(.W(W)) u_hold (
      .clk    (clk),
      .cap    (caps[i]),
      .cap_val(timer_q),
      .wr     (lds[i]),
      .wr_data(ld_data),
      .q      (holds[i])
    );
  end

  dt_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .mode     (ctrl.mode),
    .run_bit  (ctrl.run_uf),
    .load     (ld_timer),
    .load_data(ld_data),
    .rel_a    (holds[0]),
    .rel_b    (holds[1]),
    .cnt_q    (timer_q),
    .uf       (uf),
    .uf_rel_a (uf_rel_a)
  );

  assign set_a  = uf_rel_a | ((ctrl.mode == MODE_FREE) & uf) | caps[0];
  assign set_b  = caps[1];
  assign set_uf = capt & uf;

  dt_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_wr_en),
    .wr_data(cfg_wr_data),
    .set_a  (set_a),
    .set_b  (set_b),
    .set_uf (set_uf),
    .ctrl_q (ctrl),
    .irq_a  (irq_a),
    .irq_b  (irq_b)
  );

  assign ctrl_q   = ctrl;
  assign hold_a_q = holds[0];
  assign hold_b_q = holds[1];
endmodule

// File: rtl/dt_checker.sv
`timescale 1ns/1ps
module dt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_wr_en,
  input logic         ld_timer,
  input logic         ld_hold_a,
  input logic [7:0]   ctrl_q,
  input logic [W-1:0] timer_q,
  input logic [W-1:0] hold_a_q,
  input logic         irq_b
);
  a_r2_halt_modes: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q[7:5] == 3'd0 || ctrl_q[7:5] >= 3'd4) && !ld_timer) |=> $stable(timer_q));

  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[7:5] == 3'd1 && !ctrl_q[4] && !ld_timer) |=> $stable(timer_q));

  a_r5_free_wrap: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[7:5] == 3'd2 && ctrl_q[4] && timer_q == '0 && !ld_timer)
      |=> (timer_q == '1 && ctrl_q[3]));

  a_r7_no_capture_outside: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[7:5] != 3'd3 && !ld_hold_a) |=> $stable(hold_a_q));

  a_r8_pend_a_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3] && !cfg_wr_en) |=> ctrl_q[3]);

  a_r8_pend_b_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1] && !cfg_wr_en) |=> ctrl_q[1]);

  a_r9_irq_b_follows: assert property (@(posedge clk) disable iff (rst)
    irq_b == (ctrl_q[1] && ctrl_q[0]));
endmodule

bind dual_reg_timer dt_checker #(.W(W)) u_dt_checker (
  .clk      (clk),
  .rst      (rst),
  .cfg_wr_en(cfg_wr_en),
  .ld_timer (ld_timer),
  .ld_hold_a(ld_hold_a),
  .ctrl_q   (ctrl_q),
  .timer_q  (timer_q),
  .hold_a_q (hold_a_q),
  .irq_b    (irq_b)
);

// File: tb/dual_reg_timer_tb_top.sv
`timescale 1ns/1ps
module dual_reg_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_wr_en = 1'b0;
  logic [7:0]   cfg_wr_data = '0;
  logic         ld_timer = 1'b0, ld_hold_a = 1'b0, ld_hold_b = 1'b0;
  logic [W-1:0] ld_data = '0;
  logic         pin_a = 1'b0, pin_b = 1'b0;
  logic [7:0]   ctrl_q;
  logic [W-1:0] timer_q, hold_a_q, hold_b_q;
  logic         irq_a, irq_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  bit cmp_on   = 1'b0;

  always #4 clk = ~clk;

  dual_reg_timer #(.W(W)) dut_i (.*);

  // Behavioural reference model
  bit [7:0]   m_ctrl;
  bit [W-1:0] m_tmr, m_a, m_b;
  bit         m_a_ok = 1'b0, m_b_ok = 1'b0;
  bit         m_next_b;
  bit [2:0]   ha, hb;
  bit         m_irq_a, m_irq_b;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 8'h00; m_tmr = '0; m_next_b = 1'b0;
      ha = '0; hb = '0; m_irq_a = 1'b0; m_irq_b = 1'b0;
    end else begin
      int  md;
      bit  go, under, ra, rb, sa, sb, su;
      bit [W-1:0] old_t;
      bit [7:0] nc;
      md = int'(m_ctrl[7:5]);
      go = ((md == 1 || md == 2) && m_ctrl[4]) || md == 3;
      under = go && m_tmr == 0 && !ld_timer;
      ra = (md == 3) && ha[1] && !ha[2];
      rb = (md == 3) && hb[1] && !hb[2];
      old_t = m_tmr;
      sa = (under && md == 1 && !m_next_b) || (under && md == 2) || ra;
      sb = rb;
      su = under && md == 3;
      if (ld_timer) m_tmr = ld_data;
      else if (go) begin
        if (under && md == 1) m_tmr = m_next_b ? m_b : m_a;
        else m_tmr = m_tmr - 1;
      end
      if (md != 1) m_next_b = 1'b0;
      else if (under) m_next_b = !m_next_b;
      if (ra) begin m_a = old_t; m_a_ok = 1'b1; end
      else if (ld_hold_a) begin m_a = ld_data; m_a_ok = 1'b1; end
      if (rb) begin m_b = old_t; m_b_ok = 1'b1; end
      else if (ld_hold_b) begin m_b = ld_data; m_b_ok = 1'b1; end
      nc = m_ctrl;
      if (cfg_wr_en) begin
        nc[7:5] = cfg_wr_data[7:5]; nc[2] = cfg_wr_data[2]; nc[0] = cfg_wr_data[0];
      end
      nc[3] = sa || (m_ctrl[3] && (!cfg_wr_en || cfg_wr_data[3]));
      nc[1] = sb || (m_ctrl[1] && (!cfg_wr_en || cfg_wr_data[1]));
      if (md == 3) nc[4] = su || (m_ctrl[4] && (!cfg_wr_en || cfg_wr_data[4]));
      else if (cfg_wr_en) nc[4] = cfg_wr_data[4];
      m_ctrl = nc;
      m_irq_a = nc[2] && (nc[3] || (nc[7:5] == 3'd3 && nc[4]));
      m_irq_b = nc[0] && nc[1];
      ha = {ha[1:0], pin_a};
      hb = {hb[1:0], pin_b};
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R8 model ctrl_q", 32'(ctrl_q), 32'(m_ctrl));
      check("R3 model timer_q", 32'(timer_q), 32'(m_tmr));
      check("R9 model irq_a", 32'(irq_a), 32'(m_irq_a));
      check("R9 model irq_b", 32'(irq_b), 32'(m_irq_b));
      if (m_a_ok) check("R7 model hold_a_q", 32'(hold_a_q), 32'(m_a));
      if (m_b_ok) check("R7 model hold_b_q", 32'(hold_b_q), 32'(m_b));
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d; step(); cfg_wr_en = 1'b0;
  endtask

  task automatic wr_tmr(input logic [W-1:0] d);
    ld_timer = 1'b1; ld_data = d; step(); ld_timer = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] tv;
    step(3);
    rst = 1'b0;
    cmp_on = 1'b1;
    check("R1 reset ctrl", 32'(ctrl_q), 32'h00);
    check("R1 reset timer", 32'(timer_q), 32'h0);
    check("R1 reset irqs", 32'({irq_a, irq_b}), 32'h0);

    ld_data = 16'd5; ld_hold_a = 1'b1; step(); ld_hold_a = 1'b0;
    ld_data = 16'd3; ld_hold_b = 1'b1; step(); ld_hold_b = 1'b0;
    rst = 1'b1; step(2); rst = 1'b0;
    check("R1 hold_a kept through reset", 32'(hold_a_q), 32'd5);
    check("R1 hold_b kept through reset", 32'(hold_b_q), 32'd3);

    // R3 stopped reload mode holds the count
    wr_ctrl(8'h24);
    wr_tmr(16'd2);
    step(3);
    check("R3 stopped count holds", 32'(timer_q), 32'd2);

    // R4 reload alternation
    wr_ctrl(8'h34);
    step(3);
    check("R4 first reload from A", 32'(timer_q), 32'd5);
    check("R4 pending A on A reload", 32'(irq_a), 32'd1);
    wr_ctrl(8'h34);
    step(5);
    check("R4 second reload from B", 32'(timer_q), 32'd3);
    check("R4 no pending on B reload", 32'(ctrl_q[3]), 32'd0);

    // R5 free-run wrap
    wr_ctrl(8'h44);
    wr_tmr(16'd1);
    wr_ctrl(8'h54);
    step(2);
    check("R5 wrap to all ones", 32'(timer_q), 32'hFFFF);
    check("R5 pending A set on wrap", 32'(ctrl_q), 32'h5C);

    // R8 write semantics
    wr_ctrl(8'h5C);
    check("R8 write 1 keeps pending", 32'(ctrl_q[3]), 32'd1);
    wr_ctrl(8'h54);
    check("R8 write 0 clears pending", 32'(ctrl_q[3]), 32'd0);
    check("R9 irq_a drops with pending", 32'(irq_a), 32'd0);
    wr_tmr(16'd1);
    step();
    wr_ctrl(8'h54);
    check("R8 hardware set wins over clear", 32'(ctrl_q[3]), 32'd1);

    // R10 preset beats underflow
    wr_ctrl(8'h54);
    wr_tmr(16'd0);
    wr_tmr(16'd7);
    check("R10 preset wins at zero", 32'(timer_q), 32'd7);
    check("R10 no underflow on preset", 32'(ctrl_q[3]), 32'd0);

    // R7 captures
    wr_ctrl(8'h65);
    wr_tmr(16'd100);
    pin_a = 1'b1;
    step(3);
    check("R7 capture A value", 32'(hold_a_q), 32'd98);
    check("R7 pending A on capture", 32'(irq_a), 32'd1);
    pin_a = 1'b0;
    pin_b = 1'b1;
    step(3);
    check("R7 capture B value", 32'(hold_b_q), 32'd95);
    check("R9 irq_b on capture", 32'(irq_b), 32'd1);
    pin_b = 1'b0;

    // R10 capture beats software load
    wr_ctrl(8'h65);
    step(3);
    pin_a = 1'b1;
    step(2);
    tv = timer_q;
    ld_data = 16'h1234; ld_hold_a = 1'b1; step(); ld_hold_a = 1'b0;
    check("R10 capture wins over load", 32'(hold_a_q), 32'(tv));
    pin_a = 1'b0;

    // R6 capture-mode underflow pending
    wr_ctrl(8'h65);
    wr_tmr(16'd0);
    step();
    check("R6 underflow sets bit 4", 32'(ctrl_q), 32'h75);
    check("R6 irq_a from underflow", 32'(irq_a), 32'd1);

    // R11 bit 4 interpretation follows held mode
    wr_ctrl(8'h65);
    check("R11 capture mode clears bit 4", 32'(ctrl_q), 32'h65);
    wr_ctrl(8'h34);
    check("R11 write 1 to cleared pending bit 4", 32'(ctrl_q), 32'h24);
    tv = timer_q;
    step(3);
    check("R3 stopped after mode switch", 32'(timer_q), 32'(tv));

    // R7 pins ignored outside capture mode
    tv = hold_a_q;
    pin_a = 1'b1; step(4); pin_a = 1'b0; step(4);
    check("R7 pin ignored outside capture", 32'(hold_a_q), 32'(tv));
    check("R7 no pending outside capture", 32'(ctrl_q[3]), 32'd0);

    // R2 undefined mode halts
    wr_ctrl(8'hF0);
    tv = timer_q;
    step(3);
    check("R2 mode 7 halts counter", 32'(timer_q), 32'(tv));

    // Random phase against the model
    for (int i = 0; i < 6000; i++) begin
      cfg_wr_en   = ($urandom_range(0, 15) == 0);
      cfg_wr_data = {3'($urandom_range(0, 4)), 5'($urandom)};
      ld_timer    = ($urandom_range(0, 31) == 0);
      ld_hold_a   = ($urandom_range(0, 31) == 0);
      ld_hold_b   = ($urandom_range(0, 31) == 0);
      ld_data     = (($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 40)) : 16'($urandom));
      if ($urandom_range(0, 7) == 0) pin_a = ~pin_a;
      if ($urandom_range(0, 7) == 0) pin_b = ~pin_b;
      step();
    end
    cfg_wr_en = 1'b0; ld_timer = 1'b0; ld_hold_a = 1'b0; ld_hold_b = 1'b0;
    step(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule